// File: doc/BRIEF.md
# Paired-Bit Memory Boolean Unit

This block evaluates any of the sixteen two-input boolean functions bitwise on two W-bit operands without a single gate that computes the function itself. It holds a small memory of 2·W physical bits, organised as W pairs. That memory answers to 2^W logical W-bit registers, because bit i of any logical register lives in one of the two cells of pair i, picked by bit i of the register's address. Each operation issues three writes into this memory, then one read. In every write the address and the data are both taken from the set {all zeros, all ones, operand a, operand b}. Because the operands themselves serve as addresses, the result appears through the order of the writes.

A user presents an opcode and the two operands together with a one-cycle start strobe. The unit captures them, plays back the three-write program that a per-opcode step table selects, and reads the register named by the first write's address. It then shows the result together with a one-cycle done pulse. The result stays on its output until the next operation finishes.

Top module: `bw_twin_unit`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `done` is 0 and `result` is all zeros. Every memory cell also starts at zero.
- R2: A memory write of data d to logical address x sets, for every bit i, pair cell i selected by x[i] to d[i] and leaves the other cell of the pair unchanged. A read of address y returns bit i from pair cell i selected by y[i].
- R3: The opcode encodes the function as follows: 0 = all zeros, 1 = a AND b, 2 = a AND NOT b, 3 = a, 4 = NOT a AND b, 5 = b, 6 = a XOR b, 7 = a OR b, 8 = NOR, 9 = XNOR, 10 = NOT b, 11 = a OR NOT b, 12 = NOT a, 13 = NOT a OR b, 14 = NAND, 15 = all ones. `result` equals that function applied bitwise to a and b.
- R4: When start is sampled high at a clock edge with the unit idle, `done` rises after the fourth following edge. It stays high for exactly one cycle.
- R5: A start seen while an operation is in progress, including in its final cycle, is ignored. It produces no extra done pulse and does not alter the pending result.
- R6: `result` changes only in a cycle where `done` is high, and holds its value in between.
- R7: The result of an operation does not depend on what earlier operations left in the memory, so back-to-back operations with any opcode mix give correct values.
- R8: Opcode and operands are captured at the accepted start. Changing them during the operation does not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| opcode | input | 4 | Function select, encoding in R3 |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | W | Last completed result, held between operations |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
A result is due four edges after the edge that accepts its start. The bench's behavioural model keeps a countdown per accepted request and checks `done` and `result` at every falling edge, so a pulse that arrives early, late or twice shows up in the cycle where it happens. Between pulses the model expects the previous result to hold. Requests are issued back to back, during the busy window and in the completion cycle, and with operands scrambled after acceptance. This way the memory is always dirty from the previous program when a new one begins.

// File: rtl/bw_pkg.sv
package bw_pkg;

    // Source of an address or a data word for one memory write
    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_ONES = 2'd1,
        SEL_OPA  = 2'd2,
        SEL_OPB  = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e addr;
        sel_e data;
    } step_t;

    localparam int NUM_STEPS = 3;

    // Element 0 is the first write; its address also names the read
    typedef step_t [NUM_STEPS-1:0] prog_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WR0  = 3'd1,
        ST_WR1  = 3'd2,
        ST_WR2  = 3'd3,
        ST_READ = 3'd4
    } seq_state_e;

    function automatic prog_t make_prog(
        input sel_e a0, input sel_e d0,
        input sel_e a1, input sel_e d1,
        input sel_e a2, input sel_e d2
    );
        prog_t p;
        p[0] = '{addr: a0, data: d0};
        p[1] = '{addr: a1, data: d1};
        p[2] = '{addr: a2, data: d2};
        return p;
    endfunction

    // Per-opcode write program. Per bit, the memory is a two-cell array
    // r[]; the result is r[first address] after the three writes.
    function automatic prog_t lookup_prog(input logic [3:0] op);
        prog_t p;
        case (op)
            4'd0:  p = make_prog(SEL_ZERO, SEL_ZERO, SEL_OPA,  SEL_ZERO, SEL_OPB,  SEL_ZERO);
            4'd1:  p = make_prog(SEL_ZERO, SEL_ONES, SEL_OPA,  SEL_ZERO, SEL_OPB,  SEL_ZERO);
            4'd2:  p = make_prog(SEL_ZERO, SEL_ZERO, SEL_OPA,  SEL_ZERO, SEL_OPB,  SEL_OPA);
            4'd3:  p = make_prog(SEL_ZERO, SEL_ONES, SEL_OPA,  SEL_ZERO, SEL_OPB,  SEL_OPA);
            4'd4:  p = make_prog(SEL_ZERO, SEL_ZERO, SEL_OPB,  SEL_ZERO, SEL_OPA,  SEL_OPB);
            4'd5:  p = make_prog(SEL_ZERO, SEL_ONES, SEL_OPB,  SEL_ZERO, SEL_OPA,  SEL_OPB);
            4'd6:  p = make_prog(SEL_ZERO, SEL_ZERO, SEL_OPA,  SEL_ONES, SEL_OPB,  SEL_OPA);
            4'd7:  p = make_prog(SEL_ZERO, SEL_ONES, SEL_OPA,  SEL_ONES, SEL_OPB,  SEL_OPA);
            4'd8:  p = make_prog(SEL_ONES, SEL_ONES, SEL_OPA,  SEL_ZERO, SEL_OPB,  SEL_ZERO);
            4'd9:  p = make_prog(SEL_ONES, SEL_ONES, SEL_OPA,  SEL_ZERO, SEL_OPB,  SEL_OPA);
            4'd10: p = make_prog(SEL_ONES, SEL_ONES, SEL_OPA,  SEL_ONES, SEL_OPB,  SEL_ZERO);
            4'd11: p = make_prog(SEL_ONES, SEL_ONES, SEL_OPA,  SEL_ONES, SEL_OPB,  SEL_OPA);
            4'd12: p = make_prog(SEL_ONES, SEL_ONES, SEL_OPA,  SEL_ZERO, SEL_ZERO, SEL_ZERO);
            4'd13: p = make_prog(SEL_ONES, SEL_ONES, SEL_OPA,  SEL_ZERO, SEL_OPB,  SEL_ONES);
            4'd14: p = make_prog(SEL_ZERO, SEL_ZERO, SEL_OPA,  SEL_ONES, SEL_OPB,  SEL_ONES);
            default: p = make_prog(SEL_ONES, SEL_ONES, SEL_OPA, SEL_ONES, SEL_OPB,  SEL_ONES);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bw_step_rom.sv
module bw_step_rom
    import bw_pkg::*;
(
    input  logic [3:0] opcode,
    output prog_t      prog
);

    always_comb begin
        prog = lookup_prog(opcode);
    end

    // Every program starts at a constant address, so the read is fully
    // determined by the three writes (R7)
    always_comb begin
        assert (prog[0].addr == SEL_ZERO || prog[0].addr == SEL_ONES)
            else $error("p_const_first_addr_r7: first address not constant");
    end

endmodule

// File: rtl/bw_twin_mem.sv
module bw_twin_mem #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] rd_addr,
    output logic [W-1:0] rd_data
);

    // cell_lo[i] is selected when address bit i is 0, cell_hi[i] when 1
    logic [W-1:0] cell_lo;
    logic [W-1:0] cell_hi;

    for (genvar i = 0; i < W; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_lo[i] <= 1'b0;
                cell_hi[i] <= 1'b0;
            end else if (wr_en) begin
                if (wr_addr[i]) begin
                    cell_hi[i] <= wr_data[i];
                end else begin
                    cell_lo[i] <= wr_data[i];
                end
            end
        end

        assign rd_data[i] = rd_addr[i] ? cell_hi[i] : cell_lo[i];

        // R2: the cell not addressed by this write keeps its value
        p_other_cell_kept_r2: assert property (@(posedge clk) disable iff (rst)
            wr_en && wr_addr[i] |=> $stable(cell_lo[i]));
        p_other_cell_kept_hi_r2: assert property (@(posedge clk) disable iff (rst)
            wr_en && !wr_addr[i] |=> $stable(cell_hi[i]));
    end

    // R2: no write, no change anywhere
    p_idle_mem_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cell_lo) && $stable(cell_hi));

endmodule

// File: rtl/bw_sequencer.sv
module bw_sequencer
    import bw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  prog_t        prog_in,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         mem_we,
    output logic [W-1:0] mem_waddr,
    output logic [W-1:0] mem_wdata,
    output logic [W-1:0] mem_raddr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] result,
    output logic         done
);

    seq_state_e   state_q;
    seq_state_e   state_d;
    prog_t        prog_q;
    logic [W-1:0] opa_q;
    logic [W-1:0] opb_q;
    step_t        cur_step;

    function automatic logic [W-1:0] pick(input sel_e s, input logic [W-1:0] va,
                                          input logic [W-1:0] vb);
        logic [W-1:0] v;
        case (s)
            SEL_ZERO: v = '0;
            SEL_ONES: v = '1;
            SEL_OPA:  v = va;
            default:  v = vb;
        endcase
        return v;
    endfunction

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_WR0;
            ST_WR0:  state_d = ST_WR1;
            ST_WR1:  state_d = ST_WR2;
            ST_WR2:  state_d = ST_READ;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        case (state_q)
            ST_WR1:  cur_step = prog_q[1];
            ST_WR2:  cur_step = prog_q[2];
            default: cur_step = prog_q[0];
        endcase
        mem_we    = (state_q == ST_WR0) || (state_q == ST_WR1) || (state_q == ST_WR2);
        mem_waddr = pick(cur_step.addr, opa_q, opb_q);
        mem_wdata = pick(cur_step.data, opa_q, opb_q);
        mem_raddr = pick(prog_q[0].addr, opa_q, opb_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            prog_q  <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            result  <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                prog_q <= prog_in;
                opa_q  <= a;
                opb_q  <= b;
            end
            if (state_q == ST_READ) begin
                result <= mem_rdata;
                done   <= 1'b1;
            end
        end
    end

    // R4: one-cycle done pulse, preceded by the read state
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state_q) == ST_READ);
    p_write_order_r4: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_WR0 |=> state_q == ST_WR1 ##1 state_q == ST_WR2 ##1 state_q == ST_READ);

    // R5: a start during an operation does not restart it
    p_busy_ignores_start_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) && start |=> state_q != ST_WR0);

    // R6: result only moves together with done
    p_result_held_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R8: captured operands stay fixed while the program runs
    p_operands_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_IDLE && state_q != ST_READ |=> $stable(opa_q) && $stable(opb_q));

endmodule

// File: rtl/bw_twin_unit.sv
module bw_twin_unit
    import bw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [3:0]   opcode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output logic         done
);

    prog_t        prog;
    logic         mem_we;
    logic [W-1:0] mem_waddr;
    logic [W-1:0] mem_wdata;
    logic [W-1:0] mem_raddr;
    logic [W-1:0] mem_rdata;

    bw_step_rom u_rom (
        .opcode (opcode),
        .prog   (prog)
    );

    bw_sequencer #(.W(W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .prog_in   (prog),
        .a         (a),
        .b         (b),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .result    (result),
        .done      (done)
    );

    bw_twin_mem #(.W(W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mem_we),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata),
        .rd_addr (mem_raddr),
        .rd_data (mem_rdata)
    );

    // R1: outputs quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $fell(rst) |-> !done && result == '0);

endmodule

// File: tb/tb_bw_twin_unit.sv
module tb_bw_twin_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [3:0]   opcode;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] result;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bw_twin_unit #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .a(a), .b(b), .result(result), .done(done)
    );

    // R3 reference, written from the encoding list
    function automatic logic [W-1:0] ref_fn(input logic [3:0] op, input logic [W-1:0] x,
                                            input logic [W-1:0] y);
        case (op)
            4'd0:  return '0;
            4'd1:  return x & y;
            4'd2:  return x & ~y;
            4'd3:  return x;
            4'd4:  return ~x & y;
            4'd5:  return y;
            4'd6:  return x ^ y;
            4'd7:  return x | y;
            4'd8:  return ~(x | y);
            4'd9:  return ~(x ^ y);
            4'd10: return ~y;
            4'd11: return x | ~y;
            4'd12: return ~x;
            4'd13: return ~x | y;
            4'd14: return ~(x & y);
            default: return '1;
        endcase
    endfunction

    // Behavioural model: countdown per accepted request
    int           cnt = 0;
    logic         exp_done = 1'b0;
    logic [W-1:0] exp_res = '0;
    logic [W-1:0] pend = '0;
    logic [3:0]   pend_op = '0;

    always @(posedge clk) begin
        if (rst) begin
            cnt = 0; exp_done = 1'b0; exp_res = '0;
        end else begin
            exp_done = 1'b0;
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    exp_done = 1'b1;
                    exp_res = pend;
                end
            end else if (start) begin
                cnt = 4;
                pend = ref_fn(opcode, a, b);
                pend_op = opcode;
            end
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4/R5 done timing", {{(W-1){1'b0}}, done}, {{(W-1){1'b0}}, exp_done});
            if (exp_done)
                chk($sformatf("R3/R7/R8 result op %0d", pend_op), result, exp_res);
            else
                chk("R6 result held", result, exp_res);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic issue(input logic [3:0] op, input logic [W-1:0] x, input logic [W-1:0] y,
                         input bit scramble, input bit poke_busy);
        @(negedge clk);
        start = 1'b1; opcode = op; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            opcode = 4'($urandom); a = W'($urandom); b = W'($urandom); // R8
        end
        if (poke_busy) begin
            start = 1'b1;                                              // R5
            @(negedge clk);
            start = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; opcode = '0; a = '0; b = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset done", {{(W-1){1'b0}}, done}, '0);
        chk("R1 reset result", result, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", result, '0);

        // R3: all opcodes on corner operands
        for (int op = 0; op < 16; op++) begin
            issue(4'(op), 8'h33, 8'h55, 1'b0, 1'b0);
            issue(4'(op), 8'h00, 8'hFF, 1'b0, 1'b0);
            issue(4'(op), 8'hFF, 8'hFF, 1'b0, 1'b0);
            issue(4'(op), 8'h00, 8'h00, 1'b0, 1'b0);
        end
        // R7/R8: random operands, scrambled inputs, mixed opcodes
        for (int k = 0; k < 64; k++)
            issue(4'($urandom), W'($urandom), W'($urandom), 1'b1, 1'b0);
        // R5: start pulses during the busy window
        for (int k = 0; k < 16; k++)
            issue(4'(k), W'($urandom), W'($urandom), 1'b0, 1'b1);
        // R5/R7: start held high continuously, back-to-back requests
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            start = 1'b1; opcode = 4'($urandom); a = W'($urandom); b = W'($urandom);
            @(negedge clk);
        end
        start = 1'b0;
        repeat (8) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule